// File: doc/BRIEF.md
# Shared Syndrome and Error-Location Search Engine for Binary BCH Decoding

This block is the front and back end of a binary BCH decoder over GF(2^M). It has one set of per-syndrome accumulator registers and one set of reduction networks. Each network multiplies by x modulo the minimal polynomial of α^j. The block uses them in two phases that never overlap. While the phase select input is high, the block absorbs the received word P bits per cycle, highest degree first. Each accumulator keeps the remainder of the received polynomial modulo its minimal polynomial. A per-syndrome basis transform turns that remainder into S_j = R(α^j).

While the phase select input is low, a load of the error-locator coefficients starts a parallel search. The same registers then step by x^P each cycle. The search examines P code positions per cycle, from the highest position down to position zero, and raises one flag per position that is a root of the locator. In the search phase a shared group transform per row replaces the per-syndrome transforms. The key-equation solver sits between the two phases and is outside this block.

The parameters must satisfy two conditions: N ≤ 2^M − 1, and each of α^1 … α^T has a minimal polynomial of full degree M. The default is M = 4, T = 3, N = 15, P = 4, with primitive polynomial x^4 + x + 1. With these values a word takes four beats, and one leading pad bit fills the first beat.

Top module: `bch_synd_chien`

## Requirements
- R1: `sel_i` high is the syndrome phase and `sel_i` low is the search phase. A cycle with `sel_i` high ends any running search, and `err_valid_o` is low in the next cycle.
- R2: The first cycle of `sel_i` high after a cycle with it low clears every accumulator and the beat count before that cycle's beat is absorbed. A new word therefore does not depend on the previous one.
- R3: In the syndrome phase each beat with `in_valid_i` high carries P received bits. Bit P−1 is the highest degree, and beats run from degree N−1 downward. After BEATS = ceil(N/P) beats, `synd_o[(j−1)·M +: M]` holds S_j = R(α^j) for j = 1..T. A field element is written as a polynomial in α, with bit k the coefficient of α^k.
- R4: `synd_valid_o` is high for exactly the one cycle after the clock edge that takes the final beat. While `sel_i` stays high and no beat arrives, `synd_o` holds its value.
- R5: On the first beat of a word, the top PAD = BEATS·P − N bits of `in_bits_i` are leading padding and are ignored whatever their value.
- R6: Cycles with `in_valid_i` low do not advance the accumulators or the beat count.
- R7: `lam_load_i` with `sel_i` low loads Λ_j from `lam_i[(j−1)·M +: M]` for j = 1..T, with Λ_0 = 1 implied. `err_valid_o` is then high for exactly BEATS cycles, starting in the next cycle.
- R8: In search cycle τ (τ = 0 in the first cycle with `err_valid_o` high), `err_flag_o[r]` is 1 exactly when Λ(α^−e) = 0 for position e = N−1−(τ·P + r).
- R9: A flag whose index τ·P + r is N or more does not name a code position and is always 0.
- R10: `err_flag_o` is all zero whenever `err_valid_o` is low, including after reset.
- R11: During the search phase, `in_valid_i` and `in_bits_i` have no effect on the flags.
- R12: `lam_load_i` is ignored while `sel_i` is high: no search starts.
- R13: A new `lam_load_i` during a running search restarts the search at τ = 0 with the new coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Phase select: 1 syndrome, 0 search |
| in_valid_i | input | 1 | Received beat present |
| in_bits_i | input | P | Received bits, bit P−1 highest degree |
| lam_load_i | input | 1 | Load locator coefficients and start search |
| lam_i | input | T·M | Locator coefficients Λ_1..Λ_T |
| synd_o | output | T·M | Syndromes S_1..S_T |
| synd_valid_o | output | 1 | Syndromes complete (one cycle) |
| err_flag_o | output | P | Per-position root flags for this search cycle |
| err_valid_o | output | 1 | Search cycle active |

## Verification
Several behaviours are checked on every cycle:
- a phase switch to syndrome stops the search;
- flags stay silent outside a search, and no more than T flags rise in one cycle;
- the search window lasts exactly BEATS cycles after a load, and the out-of-range tail positions never flag;
- syndrome-valid only ever follows an accepted beat;
- the syndromes stay still across beat gaps.

Only the bench scenarios can show that the numbers are right. There, the syndromes of encoded words with injected errors are compared against direct evaluation of R(α^j), and the flag pattern of each cycle is compared against the injected error positions. The same scenarios show that nonzero padding, input traffic during a search, and a mid-search reload behave as required.

// File: rtl/bcsu_pkg.sv
package bcsu_pkg;

    // multiply a field element by alpha, GF(2^m) with the given primitive polynomial
    function automatic logic [15:0] gf_mulx(input logic [15:0] a, input int m,
                                            input logic [16:0] prim);
        logic [16:0] t;
        t = {1'b0, a} << 1;
        if (t[m]) t = t ^ prim;
        return t[15:0];
    endfunction

    function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                           input int m, input logic [16:0] prim);
        logic [15:0] r;
        logic [15:0] x;
        r = '0;
        x = a;
        for (int i = 0; i < m; i++) begin
            if (b[i]) r = r ^ x;
            x = gf_mulx(x, m, prim);
        end
        return r;
    endfunction

    function automatic logic [15:0] gf_pow(input int k, input int m, input logic [16:0] prim);
        logic [15:0] r;
        int e;
        e = k % ((1 << m) - 1);
        r = 16'd1;
        for (int i = 0; i < e; i++) r = gf_mulx(r, m, prim);
        return r;
    endfunction

    // element named by coordinates vec in the basis {1, a^j, a^2j, ...}
    function automatic logic [15:0] elem_of(input logic [15:0] vec, input int j,
                                            input int m, input logic [16:0] prim);
        logic [15:0] r;
        r = '0;
        for (int k = 0; k < m; k++)
            if (vec[k]) r = r ^ gf_pow(j * k, m, prim);
        return r;
    endfunction

    // coordinates of target in the basis {1, a^j, a^2j, ...} (exhaustive search)
    function automatic logic [15:0] basis_solve(input int j, input logic [15:0] target,
                                                input int m, input logic [16:0] prim);
        logic [15:0] found;
        found = '0;
        for (int v = (1 << m) - 1; v >= 0; v--)
            if (elem_of(16'(v), j, m, prim) == target) found = 16'(v);
        return found;
    endfunction

    // binary minimal polynomial of a^j, bit d = coefficient of x^d
    function automatic logic [16:0] min_poly(input int j, input int m, input logic [16:0] prim);
        logic [15:0] c [0:16];
        logic [15:0] beta;
        logic [15:0] b;
        logic [16:0] res;
        int deg;
        logic done;
        for (int i = 0; i <= 16; i++) c[i] = '0;
        c[0] = 16'd1;
        deg  = 0;
        beta = gf_pow(j, m, prim);
        b    = beta;
        done = 1'b0;
        for (int s = 0; s < m; s++) begin
            if (!done) begin
                for (int d = 16; d >= 1; d--)
                    if (d <= deg + 1) c[d] = c[d-1] ^ gf_mul(c[d], b, m, prim);
                c[0] = gf_mul(c[0], b, m, prim);
                deg  = deg + 1;
                b    = gf_mul(b, b, m, prim);
                if (b == beta) done = 1'b1;
            end
        end
        res = '0;
        for (int d = 0; d <= 16; d++) res[d] = c[d][0];
        return res;
    endfunction

endpackage

// File: rtl/bcsu_lane.sv
// One syndrome/locator lane: register arithmetic modulo the minimal polynomial of a^J.
module bcsu_lane
    import bcsu_pkg::*;
#(
    parameter int          M    = 4,
    parameter logic [16:0] PRIM = 17'h13,
    parameter int          J    = 1,
    parameter int          P    = 4,
    parameter int          I0   = 1
) (
    input  logic [M-1:0]   reg_i,
    input  logic           clr_i,
    input  logic [P-1:0]   data_i,
    input  logic [M-1:0]   lam_i,
    output logic [M-1:0]   syn_next_o,
    output logic [M-1:0]   srch_next_o,
    output logic [M-1:0]   load_o,
    output logic [P*M-1:0] rows_o,
    output logic [M-1:0]   synd_o
);
    localparam logic [16:0] MP = min_poly(J, M, PRIM);

    function automatic logic [M-1:0] step_x(input logic [M-1:0] v);
        logic [M-1:0] r;
        r = v << 1;
        if (v[M-1]) r = r ^ MP[M-1:0];
        return r;
    endfunction

    // syndrome path: acc * x^P + received bits, reduced each step
    always_comb begin
        logic [M-1:0] acc;
        acc = clr_i ? '0 : reg_i;
        for (int k = P - 1; k >= 0; k--) begin
            acc    = step_x(acc);
            acc[0] = acc[0] ^ data_i[k];
        end
        syn_next_o = acc;
    end

    // search path: rows hold reg * x^r, next state is reg * x^P
    always_comb begin
        logic [M-1:0] cur;
        cur = reg_i;
        for (int r = 0; r < P; r++) begin
            rows_o[r*M +: M] = cur;
            cur              = step_x(cur);
        end
        srch_next_o = cur;
    end

    // inverse basis transform fused with the start offset a^(J*I0)
    logic [M-1:0] load_part [M];
    logic [M-1:0] bt_part   [M];
    for (genvar b = 0; b < M; b++) begin : g_mat
        localparam logic [15:0] LCOL = basis_solve(J, gf_pow(b + J * I0, M, PRIM), M, PRIM);
        localparam logic [15:0] BCOL = gf_pow(J * b, M, PRIM);
        assign load_part[b] = lam_i[b] ? LCOL[M-1:0] : '0;
        assign bt_part[b]   = reg_i[b] ? BCOL[M-1:0] : '0;
    end

    always_comb begin
        load_o = '0;
        synd_o = '0;
        for (int b = 0; b < M; b++) begin
            load_o = load_o ^ load_part[b];
            synd_o = synd_o ^ bt_part[b];
        end
    end
endmodule

// File: rtl/bcsu_gbt.sv
// Group transform for one search row: merges all lanes by power of alpha, tests for a root.
module bcsu_gbt
    import bcsu_pkg::*;
#(
    parameter int          M    = 4,
    parameter int          T    = 3,
    parameter logic [16:0] PRIM = 17'h13
) (
    input  logic [T*M-1:0] d_i,
    output logic           hit_o
);
    localparam int V = T * (M - 1) + 1;

    logic [V-1:0] w;
    always_comb begin
        w = '0;
        for (int j = 1; j <= T; j++)
            for (int k = 0; k < M; k++)
                w[j*k] = w[j*k] ^ d_i[(j-1)*M + k];
    end

    logic [M-1:0] part [V];
    for (genvar v = 0; v < V; v++) begin : g_pow
        localparam logic [15:0] AV = gf_pow(v, M, PRIM);
        assign part[v] = w[v] ? AV[M-1:0] : '0;
    end

    always_comb begin
        logic [M-1:0] acc;
        acc    = {{(M-1){1'b0}}, 1'b1};
        for (int v = 0; v < V; v++) acc = acc ^ part[v];
        hit_o  = (acc == '0);
    end
endmodule

// File: rtl/bch_synd_chien.sv
module bch_synd_chien
    import bcsu_pkg::*;
#(
    parameter int          M    = 4,
    parameter logic [16:0] PRIM = 17'h13,
    parameter int          T    = 3,
    parameter int          N    = 15,
    parameter int          P    = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           sel_i,
    input  logic           in_valid_i,
    input  logic [P-1:0]   in_bits_i,
    input  logic           lam_load_i,
    input  logic [T*M-1:0] lam_i,
    output logic [T*M-1:0] synd_o,
    output logic           synd_valid_o,
    output logic [P-1:0]   err_flag_o,
    output logic           err_valid_o
);
    localparam int BEATS = (N + P - 1) / P;
    localparam int PAD   = BEATS * P - N;
    localparam int N0    = (1 << M) - 1;
    localparam int I0    = N0 - N + 1;
    localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);
    localparam logic [P-1:0]  KEEP = {P{1'b1}} >> PAD;

    typedef struct packed {
        logic [T*M-1:0] acc;
        logic [CW-1:0]  cnt;
        logic           srch;
        logic           syn_vld;
        logic           sel_prev;
    } state_t;

    state_t st_q, st_d;

    logic          sel_rise;
    logic [CW-1:0] cnt_base;
    logic [P-1:0]  data_m;

    always_comb begin
        sel_rise = sel_i & ~st_q.sel_prev;
        cnt_base = sel_rise ? '0 : st_q.cnt;
        data_m   = (cnt_base == '0) ? (in_bits_i & KEEP) : in_bits_i;
    end

    logic [T*M-1:0]   syn_next, srch_next, load_all;
    logic [T*P*M-1:0] rows_all;
    logic [P*T*M-1:0] row_in;
    logic [P-1:0]     hit;

    for (genvar g = 0; g < T; g++) begin : g_lane
        bcsu_lane #(.M(M), .PRIM(PRIM), .J(g + 1), .P(P), .I0(I0)) u_lane (
            .reg_i       (st_q.acc[g*M +: M]),
            .clr_i       (sel_rise),
            .data_i      (data_m),
            .lam_i       (lam_i[g*M +: M]),
            .syn_next_o  (syn_next[g*M +: M]),
            .srch_next_o (srch_next[g*M +: M]),
            .load_o      (load_all[g*M +: M]),
            .rows_o      (rows_all[g*P*M +: P*M]),
            .synd_o      (synd_o[g*M +: M])
        );
        for (genvar r = 0; r < P; r++) begin : g_wire
            assign row_in[r*T*M + g*M +: M] = rows_all[g*P*M + r*M +: M];
        end
    end

    for (genvar r = 0; r < P; r++) begin : g_row
        bcsu_gbt #(.M(M), .T(T), .PRIM(PRIM)) u_gbt (
            .d_i   (row_in[r*T*M +: T*M]),
            .hit_o (hit[r])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.syn_vld  = 1'b0;
        st_d.sel_prev = sel_i;
        if (sel_i) begin
            st_d.srch = 1'b0;
            if (sel_rise) begin
                st_d.acc = '0;
                st_d.cnt = '0;
            end
            if (in_valid_i) begin
                st_d.acc = syn_next;
                if (cnt_base == LAST) begin
                    st_d.cnt     = '0;
                    st_d.syn_vld = 1'b1;
                end else begin
                    st_d.cnt = cnt_base + CW'(1);
                end
            end
        end else if (lam_load_i) begin
            st_d.acc  = load_all;
            st_d.cnt  = '0;
            st_d.srch = 1'b1;
        end else if (st_q.srch) begin
            st_d.acc = srch_next;
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.srch = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        for (int r = 0; r < P; r++)
            err_flag_o[r] = st_q.srch & hit[r] & ((int'(st_q.cnt) * P + r) < N);
    end

    assign synd_valid_o = st_q.syn_vld;
    assign err_valid_o  = st_q.srch;
endmodule

// File: rtl/synd_chien_chk.sv
module synd_chien_chk #(
    parameter int M = 4,
    parameter int T = 3,
    parameter int N = 15,
    parameter int P = 4
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           sel_i,
    input logic           in_valid_i,
    input logic [P-1:0]   in_bits_i,
    input logic           lam_load_i,
    input logic [T*M-1:0] lam_i,
    input logic [T*M-1:0] synd_o,
    input logic           synd_valid_o,
    input logic [P-1:0]   err_flag_o,
    input logic           err_valid_o
);
    localparam int BEATS = (N + P - 1) / P;
    localparam int PAD   = BEATS * P - N;
    localparam logic [P-1:0] TAIL_OK = {P{1'b1}} >> PAD;

    int since;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    since <= 0;
        else if (lam_load_i && !sel_i)  since <= 1;
        else if (since != 0 && since <= BEATS) since <= since + 1;
    end

    p_search_stops_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |=> !err_valid_o);

    p_synd_after_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        synd_valid_o |-> $past(sel_i && in_valid_i));

    p_gap_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && $past(sel_i) && !in_valid_i) |=> $stable(synd_o));

    p_search_starts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lam_load_i && !sel_i) |=> err_valid_o);

    p_search_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_valid_o |-> (since >= 1 && since <= BEATS));

    p_root_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_valid_o |-> ($countones(err_flag_o) <= T));

    p_tail_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_valid_o && since == BEATS) |-> ((err_flag_o & ~TAIL_OK) == '0));

    p_flags_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_valid_o |-> (err_flag_o == '0));
endmodule

bind bch_synd_chien synd_chien_chk #(.M(M), .T(T), .N(N), .P(P)) u_chk (.*);

// File: tb/tb_bch_synd_chien.sv
module tb_bch_synd_chien;
    localparam int M = 4, T = 3, N = 15, P = 4;
    localparam int BEATS = (N + P - 1) / P;
    localparam int PAD   = BEATS * P - N;
    localparam logic [4:0] PRIMB = 5'h13;
    localparam logic [15:0] GEN = 16'h01D1;   // (x^4+x+1)(x^4+x^3+x^2+x+1)

    // message (7 bits) and error pattern (15 bits, bit = position)
    localparam logic [21:0] VEC [6] = '{
        {7'h55, 15'h0000}, {7'h01, 15'h4000}, {7'h7F, 15'h0001},
        {7'h2A, 15'h0210}, {7'h33, 15'h4801}, {7'h6C, 15'h1240}
    };

    logic clk = 0, rst_n = 0;
    logic sel = 0, in_valid = 0, lam_load = 0;
    logic [P-1:0]   in_bits = '0;
    logic [T*M-1:0] lam = '0;
    logic [T*M-1:0] synd;
    logic synd_valid, err_valid;
    logic [P-1:0] err_flag;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bch_synd_chien dut (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .in_valid_i(in_valid),
        .in_bits_i(in_bits), .lam_load_i(lam_load), .lam_i(lam),
        .synd_o(synd), .synd_valid_o(synd_valid),
        .err_flag_o(err_flag), .err_valid_o(err_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M:0] x;
        logic [M-1:0] r;
        r = '0;
        x = {1'b0, a};
        for (int i = 0; i < M; i++) begin
            if (b[i]) r = r ^ x[M-1:0];
            x = x << 1;
            if (x[M]) x = x ^ PRIMB;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] gpow(input int k);
        logic [M-1:0] r;
        r = 1;
        for (int i = 0; i < k % 15; i++) r = gmul(r, 4'd2);
        return r;
    endfunction

    function automatic logic [M-1:0] eval_syn(input logic [N-1:0] w, input int j);
        logic [M-1:0] s;
        s = '0;
        for (int d = 0; d < N; d++) if (w[d]) s = s ^ gpow(j * d);
        return s;
    endfunction

    function automatic logic [N-1:0] encode(input logic [6:0] msg);
        logic [N-1:0] c;
        c = '0;
        for (int i = 0; i < 7; i++) if (msg[i]) c = c ^ N'(GEN << i);
        return c;
    endfunction

    function automatic logic [T*M-1:0] lam_of(input logic [N-1:0] em);
        logic [M-1:0] l [0:T];
        logic [T*M-1:0] packed_l;
        l[0] = 1;
        for (int d = 1; d <= T; d++) l[d] = '0;
        for (int e = 0; e < N; e++)
            if (em[e]) for (int d = T; d >= 1; d--) l[d] = l[d] ^ gmul(l[d-1], gpow(e));
        for (int d = 1; d <= T; d++) packed_l[(d-1)*M +: M] = l[d];
        return packed_l;
    endfunction

    function automatic logic [P-1:0] exp_flags(input logic [N-1:0] em, input int tau);
        logic [P-1:0] f;
        f = '0;
        for (int r = 0; r < P; r++)
            if (tau * P + r < N) f[r] = em[N - 1 - (tau * P + r)];
        return f;
    endfunction

    // syndrome phase for word w; junk fills the pad bits, gap inserts idle cycles
    task automatic feed(input logic [N-1:0] w, input logic junk, input bit gap, input string tag);
        sel = 0; in_valid = 0;
        tick();
        sel = 1;
        for (int b = 0; b < BEATS; b++) begin
            for (int k = 0; k < P; k++) begin
                int idx;
                idx = b * P + (P - 1 - k) - PAD;
                in_bits[k] = (idx < 0) ? junk : w[N - 1 - idx];
            end
            in_valid = 1;
            check({tag, " R1 no search in syndrome phase"}, 32'(err_valid), 0);
            tick();
            if (gap && b < BEATS - 1) begin
                in_valid = 0; in_bits = '1;
                tick();
                check("R6 idle beat keeps valid low", 32'(synd_valid), 0);
            end
        end
        in_valid = 0;
        check({tag, " R4 synd valid after last beat"}, 32'(synd_valid), 1);
        for (int j = 1; j <= T; j++)
            check({tag, " R3/R2 syndrome"}, 32'(synd[(j-1)*M +: M]), 32'(eval_syn(w, j)));
        tick();
        check("R4 synd valid one cycle", 32'(synd_valid), 0);
        check("R4 syndrome held", 32'(synd[M-1:0]), 32'(eval_syn(w, 1)));
    endtask

    task automatic search(input logic [N-1:0] em, input bit junk_in, input string tag);
        sel = 0; lam = lam_of(em); lam_load = 1;
        tick();
        lam_load = 0;
        for (int tau = 0; tau < BEATS; tau++) begin
            check({tag, " R7 search valid"}, 32'(err_valid), 1);
            check({tag, " R8 flags"}, 32'(err_flag), 32'(exp_flags(em, tau)));
            if (tau == BEATS - 1)
                check("R9 tail position silent", 32'(err_flag >> (P - PAD)), 0);
            if (junk_in) begin in_valid = 1; in_bits = P'(tau) ^ '1; end
            tick();
            if (junk_in)
                check("R11 input ignored in search", 32'(err_flag), 32'(tau + 1 < BEATS ? exp_flags(em, tau + 1) : 0));
        end
        in_valid = 0;
        check({tag, " R7 search ends"}, 32'(err_valid), 0);
        check("R10 flags quiet after search", 32'(err_flag), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check("R10 reset flags", 32'(err_flag), 0);
        check("R10 reset search valid", 32'(err_valid), 0);
        check("R4 reset synd valid", 32'(synd_valid), 0);
        rst_n = 1;
        tick();

        for (int v = 0; v < 6; v++) begin
            logic [N-1:0] w;
            w = encode(VEC[v][21:15]) ^ VEC[v][14:0];
            feed(w, 1'b0, 1'b0, "vec");
            search(VEC[v][14:0], 1'b0, "vec");
        end

        // R5: nonzero padding on the first beat
        feed(encode(7'h33) ^ 15'h4801, 1'b1, 1'b0, "R5 pad");
        // R6: idle cycles between beats
        feed(encode(7'h2A) ^ 15'h0210, 1'b0, 1'b1, "R6 gaps");
        // R11: input traffic during search
        search(15'h1240, 1'b1, "R11");

        // R12: load while in syndrome phase
        sel = 1; tick();
        lam = lam_of(15'h0001); lam_load = 1; tick();
        lam_load = 0; tick();
        check("R12 load ignored", 32'(err_valid), 0);
        check("R12 no flags", 32'(err_flag), 0);

        // R1: phase switch stops a running search
        sel = 0; lam = lam_of(15'h0001); lam_load = 1; tick();
        lam_load = 0;
        check("R1 search running", 32'(err_valid), 1);
        sel = 1; tick();
        check("R1 search stopped by phase", 32'(err_valid), 0);

        // R13: reload mid-search
        sel = 0; lam = lam_of(15'h0001); lam_load = 1; tick();
        lam_load = 0; tick();
        lam = lam_of(15'h4000); lam_load = 1; tick();
        lam_load = 0;
        check("R13 restart valid", 32'(err_valid), 1);
        check("R13 restart at first cycle", 32'(err_flag), 32'(exp_flags(15'h4000, 0)));
        repeat (BEATS) tick();
        check("R13 ends after full window", 32'(err_valid), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule